// File: doc/BRIEF.md
# Return-From-Trap Control Unit

This unit decides the outcome of a return-from-trap instruction. Each time the issue stage presents such an instruction, the unit looks at the current processor status (supervisor bit, previous-supervisor bit, trap-enable bit, debug-mode flag) and at the debug-select field of the instruction. From these it picks one outcome and reports it one clock later: the program counter to continue at, the restored supervisor and trap-enable values with a write strobe, and any halt, illegal-instruction or leave-debug request.

The conditions are tested in a fixed priority order. A return issued outside supervisor mode only advances the PC, and it also halts when traps are disabled. A return issued while traps are still enabled is illegal. A genuine return takes one of two paths. The normal path resumes at the saved normal return PC, turns traps back on and restores the supervisor bit from the previous-supervisor bit. The debug path resumes at the saved debug return PC, restores both bits from the saved debug copies and leaves debug mode. Any other combination only advances the PC.

Top module: `rett_ctrl`

## Requirements
- R1: During and right after a synchronous reset, with no instruction accepted since, `next_pc` is 0 and `new_sup`, `new_trap_en`, `stat_we`, `halt_req`, `illegal_req` and `dbg_exit` are all 0.
- R2: An instruction with `sup_bit`=0 and `trap_en`=0 produces `halt_req`=1 and `next_pc`=`cur_pc`+4, with no other request and no status strobe.
- R3: An instruction with `sup_bit`=0 and `trap_en`=1 produces `next_pc`=`cur_pc`+4 and raises no request and no status strobe.
- R4: An instruction with `sup_bit`=1 and `trap_en`=1 produces `illegal_req`=1 and `next_pc`=`cur_pc`+4, with no halt and no status strobe, whatever the debug flag and field.
- R5: An instruction with `sup_bit`=1, `trap_en`=0, `dbg_mode`=0 and `dbg_sel`=0 produces `next_pc`=`saved_pc`, `new_trap_en`=1, `new_sup`=`prev_sup_bit`, `stat_we`=1 and `dbg_exit`=0.
- R6: An instruction with `sup_bit`=1, `trap_en`=0, `dbg_mode`=1 and `dbg_sel`=1 produces `next_pc`=`saved_dbg_pc`, `new_sup`=`saved_dbg_sup`, `new_trap_en`=`saved_dbg_trap_en`, `stat_we`=1 and `dbg_exit`=1.
- R7: An instruction with `sup_bit`=1, `trap_en`=0 and `dbg_mode`≠`dbg_sel` produces `next_pc`=`cur_pc`+4, `new_sup`=`sup_bit`, `new_trap_en`=`trap_en`, and no request or strobe.
- R8: In any cycle after which `insn_vld` was 0, `stat_we`, `halt_req`, `illegal_req` and `dbg_exit` are 0, and `next_pc`, `new_sup`, `new_trap_en` keep their previous values.
- R9: All outputs change exactly one clock after the edge that samples `insn_vld`=1. Strobes last one cycle per instruction, so back-to-back returns give one pulse each.
- R10: `cur_pc`+4 wraps modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_vld | input | 1 | A return-from-trap instruction is presented this cycle |
| cur_pc | input | PC_W | Address of that instruction |
| sup_bit | input | 1 | Current supervisor bit |
| prev_sup_bit | input | 1 | Previous-supervisor bit |
| trap_en | input | 1 | Current trap-enable bit |
| dbg_mode | input | 1 | Processor is in debug mode |
| dbg_sel | input | 1 | Debug-select field of the instruction |
| saved_pc | input | PC_W | Saved normal return PC |
| saved_dbg_pc | input | PC_W | Saved debug return PC |
| saved_dbg_sup | input | 1 | Saved debug-mode supervisor bit |
| saved_dbg_trap_en | input | 1 | Saved debug-mode trap-enable bit |
| next_pc | output | PC_W | PC to continue at |
| new_sup | output | 1 | Supervisor bit to write |
| new_trap_en | output | 1 | Trap-enable bit to write |
| stat_we | output | 1 | One-cycle status write strobe |
| halt_req | output | 1 | Halt request |
| illegal_req | output | 1 | Illegal-instruction request |
| dbg_exit | output | 1 | One-cycle request to leave debug mode |

## Verification
The bench holds a reference model that sees only the port values. It predicts every output for the next clock and compares all of them each cycle. A wrong priority choice shows up on the cycle right after that instruction as the wrong request, the wrong PC source or a strobe that should not be there. Stale or held state shows up one cycle after the next idle or back-to-back instruction, because pulses must drop and held values must not move. Directed cases cover every status combination, the PC wrap point and reset in the middle of a run. Random traffic then mixes valid and idle cycles.

// File: rtl/rett_pkg.sv
// Shared types for the return-from-trap control unit.
// Assumes nothing beyond the IEEE 1800-2017 language.
package rett_pkg;

    // Which outcome the priority decode selected.
    typedef enum logic [2:0] {
        PATH_USER_HALT = 3'd0,  // not supervisor, traps off
        PATH_USER      = 3'd1,  // not supervisor, traps on
        PATH_ILLEGAL   = 3'd2,  // supervisor with traps still on
        PATH_RET_NORM  = 3'd3,  // normal return
        PATH_RET_DBG   = 3'd4,  // debug return
        PATH_SKIP      = 3'd5   // mismatched debug flag and field
    } rett_path_e;

    // Status and request bits produced for one instruction.
    typedef struct packed {
        logic sup;
        logic trap_en;
        logic we;
        logic halt;
        logic illegal;
        logic dexit;
    } rett_flags_t;

    localparam logic [2:0] PC_STEP = 3'd4;

endpackage

// File: rtl/rett_decide.sv
// Combinational priority decode of a return-from-trap instruction.
// Assumes its inputs are stable for the cycle the caller samples them.
module rett_decide
    import rett_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0] cur_pc,
    input  logic            sup_bit,
    input  logic            prev_sup_bit,
    input  logic            trap_en,
    input  logic            dbg_mode,
    input  logic            dbg_sel,
    input  logic [PC_W-1:0] saved_pc,
    input  logic [PC_W-1:0] saved_dbg_pc,
    input  logic            saved_dbg_sup,
    input  logic            saved_dbg_trap_en,
    output rett_path_e      path,
    output logic [PC_W-1:0] pc_out,
    output rett_flags_t     flags
);

    logic [PC_W-1:0] pc_inc;

    // Sequential address, wrapping at the top of the address space.
    always_comb pc_inc = cur_pc + PC_W'(PC_STEP);

    // Pick the outcome in fixed priority order.
    always_comb begin
        if (!sup_bit)
            path = trap_en ? PATH_USER : PATH_USER_HALT;
        else if (trap_en)
            path = PATH_ILLEGAL;
        else if (!dbg_mode && !dbg_sel)
            path = PATH_RET_NORM;
        else if (dbg_mode && dbg_sel)
            path = PATH_RET_DBG;
        else
            path = PATH_SKIP;
    end

    // Produce the PC and flag values for the selected outcome.
    always_comb begin
        pc_out        = pc_inc;
        flags         = '0;
        flags.sup     = sup_bit;
        flags.trap_en = trap_en;
        unique case (path)
            PATH_USER_HALT: flags.halt    = 1'b1;
            PATH_ILLEGAL:   flags.illegal = 1'b1;
            PATH_RET_NORM: begin
                pc_out        = saved_pc;
                flags.sup     = prev_sup_bit;
                flags.trap_en = 1'b1;
                flags.we      = 1'b1;
            end
            PATH_RET_DBG: begin
                pc_out        = saved_dbg_pc;
                flags.sup     = saved_dbg_sup;
                flags.trap_en = saved_dbg_trap_en;
                flags.we      = 1'b1;
                flags.dexit   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rett_outreg.sv
// Output register stage: loads a decision on a valid instruction, clears
// pulses when idle and holds PC and status. Synchronous active-low reset.
module rett_outreg
    import rett_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PC_W-1:0] pc_in,
    input  rett_flags_t     flags_in,
    output logic [PC_W-1:0] pc_q,
    output rett_flags_t     flags_q
);

    // Capture a decision, or drop the pulses and hold the rest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            flags_q <= '0;
        end else if (load) begin
            pc_q    <= pc_in;
            flags_q <= flags_in;
        end else begin
            flags_q.we      <= 1'b0;
            flags_q.halt    <= 1'b0;
            flags_q.illegal <= 1'b0;
            flags_q.dexit   <= 1'b0;
        end
    end

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flags_q.we, flags_q.halt, flags_q.illegal})) else $error("one request");  // R4
    AST_EXIT_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q.dexit |-> flags_q.we) else $error("exit without write");  // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> !flags_q.we && !flags_q.halt && !flags_q.illegal && !flags_q.dexit) else $error("idle pulse");  // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(pc_q) && $stable(flags_q.sup) && $stable(flags_q.trap_en)) else $error("idle hold");  // R8

endmodule

// File: rtl/rett_ctrl.sv
// Return-from-trap control unit top. Decodes a presented instruction and
// registers the result; all outputs valid one clock after insn_vld.
// Assumes inputs are synchronous to clk and reset is synchronous, active low.
module rett_ctrl
    import rett_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_vld,
    input  logic [PC_W-1:0] cur_pc,
    input  logic            sup_bit,
    input  logic            prev_sup_bit,
    input  logic            trap_en,
    input  logic            dbg_mode,
    input  logic            dbg_sel,
    input  logic [PC_W-1:0] saved_pc,
    input  logic [PC_W-1:0] saved_dbg_pc,
    input  logic            saved_dbg_sup,
    input  logic            saved_dbg_trap_en,
    output logic [PC_W-1:0] next_pc,
    output logic            new_sup,
    output logic            new_trap_en,
    output logic            stat_we,
    output logic            halt_req,
    output logic            illegal_req,
    output logic            dbg_exit
);

    rett_path_e      dec_path;
    logic [PC_W-1:0] dec_pc;
    rett_flags_t     dec_flags;
    logic [PC_W-1:0] reg_pc;
    rett_flags_t     reg_flags;

    rett_decide #(.PC_W(PC_W)) u_decide (
        .cur_pc            (cur_pc),
        .sup_bit           (sup_bit),
        .prev_sup_bit      (prev_sup_bit),
        .trap_en           (trap_en),
        .dbg_mode          (dbg_mode),
        .dbg_sel           (dbg_sel),
        .saved_pc          (saved_pc),
        .saved_dbg_pc      (saved_dbg_pc),
        .saved_dbg_sup     (saved_dbg_sup),
        .saved_dbg_trap_en (saved_dbg_trap_en),
        .path              (dec_path),
        .pc_out            (dec_pc),
        .flags             (dec_flags)
    );

    rett_outreg #(.PC_W(PC_W)) u_outreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (insn_vld),
        .pc_in    (dec_pc),
        .flags_in (dec_flags),
        .pc_q     (reg_pc),
        .flags_q  (reg_flags)
    );

    // Drive the ports from the register stage.
    always_comb begin
        next_pc     = reg_pc;
        new_sup     = reg_flags.sup;
        new_trap_en = reg_flags.trap_en;
        stat_we     = reg_flags.we;
        halt_req    = reg_flags.halt;
        illegal_req = reg_flags.illegal;
        dbg_exit    = reg_flags.dexit;
    end

    AST_HALT_USER: assert property (@(posedge clk) disable iff (!rst_n)
        insn_vld && !sup_bit && !trap_en |=> halt_req && !stat_we) else $error("halt");  // R2
    AST_USER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        insn_vld && !sup_bit |=> next_pc == $past(cur_pc) + PC_W'(PC_STEP)) else $error("user step");  // R3
    AST_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        insn_vld && sup_bit && trap_en |=> illegal_req && !halt_req) else $error("illegal");  // R4
    AST_NORM_RET: assert property (@(posedge clk) disable iff (!rst_n)
        insn_vld && sup_bit && !trap_en && !dbg_mode && !dbg_sel
        |=> next_pc == $past(saved_pc) && new_trap_en && stat_we && !dbg_exit) else $error("normal return");  // R5
    AST_DBG_RET: assert property (@(posedge clk) disable iff (!rst_n)
        insn_vld && sup_bit && !trap_en && dbg_mode && dbg_sel
        |=> next_pc == $past(saved_dbg_pc) && dbg_exit) else $error("debug return");  // R6
    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        insn_vld && sup_bit && !trap_en && (dbg_mode != dbg_sel)
        |=> !stat_we && !halt_req && !illegal_req && !dbg_exit) else $error("skip");  // R7

endmodule

// File: tb/rett_ctrl_tb.sv
// Bench: behavioural reference model compared on every clock.
module rett_ctrl_tb;

    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            insn_vld = 1'b0;
    logic [PC_W-1:0] cur_pc = '0;
    logic            sup_bit = 1'b0, prev_sup_bit = 1'b0, trap_en = 1'b0;
    logic            dbg_mode = 1'b0, dbg_sel = 1'b0;
    logic [PC_W-1:0] saved_pc = '0, saved_dbg_pc = '0;
    logic            saved_dbg_sup = 1'b0, saved_dbg_trap_en = 1'b0;
    logic [PC_W-1:0] next_pc;
    logic            new_sup, new_trap_en, stat_we, halt_req, illegal_req, dbg_exit;

    int n_checks = 0;
    int n_fail   = 0;

    // Model state: expected outputs after the most recent edge.
    logic [PC_W-1:0] e_pc = '0;
    logic [5:0]      e_fl = '0;  // {sup, trap_en, we, halt, illegal, dexit}
    string           e_tag = "R1";
    bit              primed = 0;

    always #2 clk = ~clk;  // 250 MHz

    rett_ctrl #(.PC_W(PC_W)) u_dut (.*);

    // Compare every output with the model on the falling edge.
    task automatic check_now();
        logic [5:0] got;
        got = {new_sup, new_trap_en, stat_we, halt_req, illegal_req, dbg_exit};
        n_checks++;
        if (got !== e_fl || next_pc !== e_pc) begin
            n_fail++;
            $display("FAIL %s: pc=%h flags=%b expected pc=%h flags=%b", e_tag, next_pc, got, e_pc, e_fl);
        end
    endtask

    // Predict the state after the coming rising edge from driven inputs.
    task automatic predict();
        logic [PC_W-1:0] inc;
        inc = cur_pc + 32'd4;
        if (!rst_n) begin
            e_pc = '0; e_fl = '0; e_tag = "R1";
        end else if (!insn_vld) begin
            e_fl[3:0] = 4'b0; e_tag = "R8";
        end else if (!sup_bit && !trap_en) begin
            e_pc = inc; e_fl = {sup_bit, trap_en, 4'b0100}; e_tag = "R2";
        end else if (!sup_bit) begin
            e_pc = inc; e_fl = {sup_bit, trap_en, 4'b0000}; e_tag = "R3";
        end else if (trap_en) begin
            e_pc = inc; e_fl = {sup_bit, trap_en, 4'b0010}; e_tag = "R4";
        end else if (!dbg_mode && !dbg_sel) begin
            e_pc = saved_pc; e_fl = {prev_sup_bit, 1'b1, 4'b1000}; e_tag = "R5";
        end else if (dbg_mode && dbg_sel) begin
            e_pc = saved_dbg_pc; e_fl = {saved_dbg_sup, saved_dbg_trap_en, 4'b1001}; e_tag = "R6";
        end else begin
            e_pc = inc; e_fl = {sup_bit, trap_en, 4'b0000}; e_tag = "R7";
        end
        if (insn_vld && rst_n && cur_pc == '1 - 32'd1) e_tag = "R10";
    endtask

    // One cycle: check current outputs, drive new inputs, predict.
    task automatic step(input bit r, input bit v, input logic [PC_W-1:0] pc,
                        input logic [3:0] st, input logic [1:0] dbg);
        @(negedge clk);
        if (primed) check_now();
        rst_n = r; insn_vld = v; cur_pc = pc;
        {sup_bit, prev_sup_bit, trap_en} = st[2:0];
        {dbg_mode, dbg_sel} = dbg;
        saved_dbg_sup = st[3]; saved_dbg_trap_en = ~st[3];
        saved_pc = pc ^ 32'h5A5A_0000; saved_dbg_pc = pc ^ 32'h0000_A5A4;
        predict();
        primed = 1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        // R1: reset state
        step(0, 0, 0, 4'h0, 2'b00);
        step(0, 1, 32'h100, 4'h7, 2'b11);
        step(1, 0, 0, 4'h0, 2'b00);
        // R2 halt; R3 user step; st = {dsup, S, PS, ET}
        step(1, 1, 32'h1000, 4'b0000, 2'b00);
        step(1, 1, 32'h2000, 4'b0001, 2'b11);
        // R4 illegal under every debug combination
        for (int d = 0; d < 4; d++) step(1, 1, 32'h3000 + d*16, 4'b0101, 2'(d));
        // R5 normal return, both PS values
        step(1, 1, 32'h4000, 4'b0110, 2'b00);
        step(1, 1, 32'h4010, 4'b0100, 2'b00);
        // R6 debug return, both saved-bit patterns
        step(1, 1, 32'h5000, 4'b1100, 2'b11);
        step(1, 1, 32'h5010, 4'b0100, 2'b11);
        // R7 mismatched debug flag and field
        step(1, 1, 32'h6000, 4'b0110, 2'b10);
        step(1, 1, 32'h6010, 4'b0100, 2'b01);
        // R8 idle after a return: pulses drop, values hold
        step(1, 1, 32'h7000, 4'b0110, 2'b00);
        step(1, 0, 32'h7777, 4'b0101, 2'b00);
        step(1, 0, 32'h7777, 4'b0000, 2'b00);
        // R9 back-to-back returns give one pulse each
        step(1, 1, 32'h8000, 4'b1100, 2'b11);
        step(1, 1, 32'h8010, 4'b0100, 2'b00);
        step(1, 0, 0, 4'b0, 2'b00);
        // R10 wrap of the sequential address
        step(1, 1, 32'hFFFF_FFFE, 4'b0001, 2'b00);
        step(1, 1, 32'hFFFF_FFFC, 4'b0101, 2'b00);
        // R1 reset in mid run
        step(0, 1, 32'h9000, 4'b0110, 2'b00);
        step(1, 0, 0, 4'b0, 2'b00);
        // Random mix of valid and idle cycles
        for (int i = 0; i < 3000; i++)
            step(($urandom % 50) != 0, $urandom % 3 != 0, $urandom, 4'($urandom), 2'($urandom));
        step(1, 0, 0, 4'b0, 2'b00);
        @(negedge clk);
        check_now();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule